// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds the eight 16-bit general registers of a processor datapath. The first four registers can also be reached as separate 8-bit halves, so byte and word accesses share the same storage. A byte write therefore has to merge its 8 bits into the existing 16-bit register.

Each cycle, two read ports and one write port are served. Every port carries a register index and a width flag that selects byte or word access. A separate pair-load port writes the accumulator and the data register on the same edge. A multiplier uses it to return the low and high words of a 32-bit product.

Reads are combinational and see writes of the current cycle. This includes partial byte merges and pair loads. The instruction decoder and the ALU can therefore use the file without a forwarding network of their own.

Top module: `gpr_file`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to 0000h. The cleared value is visible on both read ports once reset is released.
- R2: In word mode (width flag 0), index 0..7 selects the 16-bit registers in this order: accumulator, count, data, base, stack pointer, base pointer, source index, destination index.
- R3: In byte mode (width flag 1), index bits [1:0] select one of registers 0..3. Index bit [2] selects the half: 0 picks bits [7:0] and 1 picks bits [15:8]. Indices 0..3 are therefore the low halves and indices 4..7 the high halves.
- R4: A byte write uses only write-data bits [7:0] and changes only the addressed half. The other half of that register and all other registers keep their values.
- R5: A byte read returns the selected half in bits [7:0], with bits [15:8] forced to zero.
- R6: A read in the same cycle as a write to the register it addresses returns the value that will be stored at the next edge. For a byte write, that value is the merged word.
- R7: The two read ports decode their index and width independently and may address different registers, or differently sized views, in the same cycle.
- R8: When the pair-load enable is high, the accumulator (register 0) takes the low word and the data register (register 2) takes the high word, both on the same edge.
- R9: If the pair load and the single write port target the same register in one cycle, the pair load value is stored. A single write to any other register in that cycle is still performed.
- R10: A word write changes only the register it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single write enable |
| wr_idx | input | 3 | Write register index |
| wr_byte | input | 1 | Write width flag, 1 = byte |
| wr_data | input | 16 | Write data (bits [7:0] in byte mode) |
| dw_en | input | 1 | Pair-load enable |
| dw_lo | input | 16 | Pair-load word for the accumulator |
| dw_hi | input | 16 | Pair-load word for the data register |
| ra_idx | input | 3 | Read port A index |
| ra_byte | input | 1 | Read port A width flag, 1 = byte |
| ra_data | output | 16 | Read port A data |
| rb_idx | input | 3 | Read port B index |
| rb_byte | input | 1 | Read port B width flag, 1 = byte |
| rb_data | output | 16 | Read port B data |

## Verification
Word writes followed by byte reads of both halves show whether the half mapping of bit [2] is right. Reads of index 4 after a stack-pointer write show that byte mode never reaches the upper four registers. Byte writes whose upper data bits are non-zero, followed by full-word reads, reveal a lane that leaks or a merge that drops the untouched half. Same-cycle write-and-read patterns separate a true bypass from a read of stale storage. Pair loads issued alone, against an overlapping byte write and alongside a write to an unrelated register show the priority rule and the independence of the two write paths.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    // Geometry of the register file
    localparam int GPR_COUNT   = 8;
    localparam int GPR_WORD_W  = 16;
    localparam int GPR_BYTE_W  = GPR_WORD_W / 2;
    localparam int GPR_IDX_W   = $clog2(GPR_COUNT);
    localparam int SPLIT_COUNT = 4;
    localparam int SPLIT_IDX_W = $clog2(SPLIT_COUNT);
    localparam int EXT_W       = GPR_WORD_W - GPR_BYTE_W;

    // Fixed roles used by the pair-load path
    localparam int ACC_IDX  = 0;
    localparam int DATA_IDX = 2;

    typedef logic [GPR_BYTE_W-1:0] byte_t;
    typedef logic [GPR_WORD_W-1:0] word_t;
    typedef logic [GPR_IDX_W-1:0]  idx_t;
    typedef logic [SPLIT_IDX_W-1:0] split_idx_t;
    typedef logic [GPR_COUNT-1:0]  reg_mask_t;
    typedef logic [GPR_COUNT-1:0][GPR_BYTE_W-1:0] lane_bank_t;

    typedef enum logic {
        ACC_WORD = 1'b0,
        ACC_BYTE = 1'b1
    } acc_width_e;

    typedef struct packed {
        logic       en;
        idx_t       idx;
        acc_width_e width;
        word_t      data;
    } wr_req_t;

    typedef struct packed {
        logic  en;
        word_t lo_word;
        word_t hi_word;
    } pair_req_t;

    // Byte view: low index bits pick the split register
    function automatic split_idx_t byte_reg(input idx_t idx);
        return idx[SPLIT_IDX_W-1:0];
    endfunction

    // Byte view: top index bit picks the upper half
    function automatic logic byte_is_hi(input idx_t idx);
        return idx[GPR_IDX_W-1];
    endfunction

    function automatic word_t zext_byte(input byte_t b);
        return {{EXT_W{1'b0}}, b};
    endfunction

    function automatic word_t join_halves(input byte_t hi, input byte_t lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/gpr_write_decode.sv
module gpr_write_decode
    import gpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_req_t    wr,
    input  pair_req_t  pair,
    output reg_mask_t  we_lo,
    output reg_mask_t  we_hi,
    output lane_bank_t d_lo,
    output lane_bank_t d_hi
);

    for (genvar g = 0; g < GPR_COUNT; g++) begin : g_reg
        localparam idx_t MY_IDX = idx_t'(g);

        logic  word_hit;
        logic  byte_lo_hit;
        logic  byte_hi_hit;
        logic  pair_hit;
        word_t pair_word;

        assign word_hit = wr.en && (wr.width == ACC_WORD) && (wr.idx == MY_IDX);

        if (g < SPLIT_COUNT) begin : g_split
            localparam split_idx_t MY_SPLIT = split_idx_t'(g);
            logic byte_sel;
            assign byte_sel    = wr.en && (wr.width == ACC_BYTE)
                                 && (byte_reg(wr.idx) == MY_SPLIT);
            assign byte_lo_hit = byte_sel && !byte_is_hi(wr.idx);
            assign byte_hi_hit = byte_sel &&  byte_is_hi(wr.idx);
        end else begin : g_plain
            assign byte_lo_hit = 1'b0;
            assign byte_hi_hit = 1'b0;
        end

        if (g == ACC_IDX) begin : g_pair_lo
            assign pair_hit  = pair.en;
            assign pair_word = pair.lo_word;
        end else if (g == DATA_IDX) begin : g_pair_hi
            assign pair_hit  = pair.en;
            assign pair_word = pair.hi_word;
        end else begin : g_no_pair
            assign pair_hit  = 1'b0;
            assign pair_word = '0;
        end

        // Pair load takes both lanes and wins over the single port
        always_comb begin
            we_lo[g] = pair_hit || word_hit || byte_lo_hit;
            we_hi[g] = pair_hit || word_hit || byte_hi_hit;
            if (pair_hit) begin
                d_lo[g] = pair_word[GPR_BYTE_W-1:0];
                d_hi[g] = pair_word[GPR_WORD_W-1:GPR_BYTE_W];
            end else if (word_hit) begin
                d_lo[g] = wr.data[GPR_BYTE_W-1:0];
                d_hi[g] = wr.data[GPR_WORD_W-1:GPR_BYTE_W];
            end else begin
                d_lo[g] = wr.data[GPR_BYTE_W-1:0];
                d_hi[g] = wr.data[GPR_BYTE_W-1:0];
            end
        end
    end

    // A lone byte write must open exactly one lane of the whole file
    assert_single_lane_R4: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.width == ACC_BYTE && !pair.en) |-> ($countones({we_hi, we_lo}) == 1));

    // A lone word write opens both lanes of exactly one register
    assert_word_one_reg_R10: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.width == ACC_WORD && !pair.en) |-> ($countones({we_hi, we_lo}) == 2 && we_hi == we_lo));

endmodule

// File: rtl/gpr_store.sv
module gpr_store
    import gpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  reg_mask_t  we_lo,
    input  reg_mask_t  we_hi,
    input  lane_bank_t d_lo,
    input  lane_bank_t d_hi,
    output lane_bank_t q_lo,
    output lane_bank_t q_hi,
    output lane_bank_t nxt_lo,
    output lane_bank_t nxt_hi
);

    for (genvar g = 0; g < GPR_COUNT; g++) begin : g_lane
        // Next-state view doubles as the write-through path
        assign nxt_lo[g] = we_lo[g] ? d_lo[g] : q_lo[g];
        assign nxt_hi[g] = we_hi[g] ? d_hi[g] : q_hi[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                q_lo[g] <= '0;
                q_hi[g] <= '0;
            end else begin
                q_lo[g] <= nxt_lo[g];
                q_hi[g] <= nxt_hi[g];
            end
        end

        assert_hold_lo_R4: assert property (@(posedge clk) disable iff (rst)
            !we_lo[g] |=> $stable(q_lo[g]));
        assert_hold_hi_R4: assert property (@(posedge clk) disable iff (rst)
            !we_hi[g] |=> $stable(q_hi[g]));
    end

    logic rst_d;
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d === 1'b1 && !rst) begin
            assert_reset_zero_R1: assert (q_lo == '0 && q_hi == '0);
        end
    end

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  idx_t       idx,
    input  acc_width_e width,
    input  lane_bank_t lo,
    input  lane_bank_t hi,
    output word_t      data
);

    split_idx_t sreg;
    byte_t      sel_byte;

    always_comb begin
        sreg     = byte_reg(idx);
        sel_byte = byte_is_hi(idx) ? hi[sreg] : lo[sreg];
        if (width == ACC_WORD) begin
            data = join_halves(hi[idx], lo[idx]);
        end else begin
            data = zext_byte(sel_byte);
        end
    end

    assert_zext_R5: assert property (@(posedge clk) disable iff (rst)
        (width == ACC_BYTE) |-> (data[GPR_WORD_W-1:GPR_BYTE_W] == '0));

endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_idx,
    input  logic        wr_byte,
    input  logic [15:0] wr_data,
    input  logic        dw_en,
    input  logic [15:0] dw_lo,
    input  logic [15:0] dw_hi,
    input  logic [2:0]  ra_idx,
    input  logic        ra_byte,
    output logic [15:0] ra_data,
    input  logic [2:0]  rb_idx,
    input  logic        rb_byte,
    output logic [15:0] rb_data
);

    localparam int RD_PORTS = 2;

    wr_req_t    wr;
    pair_req_t  pair;
    reg_mask_t  we_lo, we_hi;
    lane_bank_t d_lo, d_hi;
    lane_bank_t q_lo, q_hi;
    lane_bank_t nxt_lo, nxt_hi;

    idx_t       rd_idx   [RD_PORTS];
    acc_width_e rd_width [RD_PORTS];
    word_t      rd_data  [RD_PORTS];

    assign wr.en    = wr_en;
    assign wr.idx   = wr_idx;
    assign wr.width = acc_width_e'(wr_byte);
    assign wr.data  = wr_data;

    assign pair.en      = dw_en;
    assign pair.lo_word = dw_lo;
    assign pair.hi_word = dw_hi;

    assign rd_idx[0]   = ra_idx;
    assign rd_width[0] = acc_width_e'(ra_byte);
    assign rd_idx[1]   = rb_idx;
    assign rd_width[1] = acc_width_e'(rb_byte);
    assign ra_data     = rd_data[0];
    assign rb_data     = rd_data[1];

    gpr_write_decode i_decode (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .pair  (pair),
        .we_lo (we_lo),
        .we_hi (we_hi),
        .d_lo  (d_lo),
        .d_hi  (d_hi)
    );

    gpr_store i_store (
        .clk    (clk),
        .rst    (rst),
        .we_lo  (we_lo),
        .we_hi  (we_hi),
        .d_lo   (d_lo),
        .d_hi   (d_hi),
        .q_lo   (q_lo),
        .q_hi   (q_hi),
        .nxt_lo (nxt_lo),
        .nxt_hi (nxt_hi)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        gpr_read_port i_port (
            .clk   (clk),
            .rst   (rst),
            .idx   (rd_idx[p]),
            .width (rd_width[p]),
            .lo    (nxt_lo),
            .hi    (nxt_hi),
            .data  (rd_data[p])
        );
    end

    // Pair load lands in both target registers on one edge, whatever else is written
    assert_pair_load_R8: assert property (@(posedge clk) disable iff (rst)
        dw_en |=> ({q_hi[ACC_IDX], q_lo[ACC_IDX]} == $past(dw_lo)
                   && {q_hi[DATA_IDX], q_lo[DATA_IDX]} == $past(dw_hi)));

    // With no write in flight, a word read shows the stored register
    assert_plain_read_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !dw_en && !ra_byte) |-> (ra_data == {q_hi[ra_idx], q_lo[ra_idx]}));

endmodule

// File: tb/test_gpr_file.sv
module test_gpr_file;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic        wr_byte = 1'b0;
    logic [15:0] wr_data = '0;
    logic        dw_en = 1'b0;
    logic [15:0] dw_lo = '0;
    logic [15:0] dw_hi = '0;
    logic [2:0]  ra_idx = '0;
    logic        ra_byte = 1'b0;
    logic [15:0] ra_data;
    logic [2:0]  rb_idx = '0;
    logic        rb_byte = 1'b0;
    logic [15:0] rb_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    gpr_file i_gpr_file (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_data(wr_data),
        .dw_en(dw_en), .dw_lo(dw_lo), .dw_hi(dw_hi),
        .ra_idx(ra_idx), .ra_byte(ra_byte), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_byte(rb_byte), .rb_data(rb_data)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  widx;
        logic        wbyte;
        logic [15:0] wdata;
        logic [2:0]  ridx;
        logic        rbyte;
        logic [15:0] exp;
    } vec_t;

    localparam int NVEC = 12;
    // Each row: write this cycle, read port A this cycle, expected read (bypass included)
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 3'd0, 1'b0, 16'h1234, 3'd0, 1'b0, 16'h1234},  // word write/read acc
        '{1'b1, 3'd4, 1'b1, 16'h00AB, 3'd0, 1'b0, 16'hAB34},  // high half of acc, merged bypass
        '{1'b1, 3'd0, 1'b1, 16'h00CD, 3'd4, 1'b1, 16'h00AB},  // low half write, read high half
        '{1'b0, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 16'hABCD},  // stored merge
        '{1'b1, 3'd3, 1'b0, 16'hBEEF, 3'd7, 1'b1, 16'h00BE},  // base reg, high byte view
        '{1'b1, 3'd3, 1'b1, 16'h0011, 3'd3, 1'b0, 16'hBE11},  // low byte of base
        '{1'b1, 3'd4, 1'b0, 16'hFFFE, 3'd4, 1'b1, 16'h00AB},  // byte idx 4 is acc high, not SP
        '{1'b0, 3'd0, 1'b0, 16'h0000, 3'd4, 1'b0, 16'hFFFE},  // stack pointer word
        '{1'b1, 3'd6, 1'b1, 16'h0077, 3'd2, 1'b0, 16'h7700},  // data reg high half
        '{1'b1, 3'd2, 1'b1, 16'h55AA, 3'd2, 1'b0, 16'h77AA},  // upper data bits ignored
        '{1'b1, 3'd7, 1'b0, 16'h0F0F, 3'd6, 1'b0, 16'h0000},  // neighbour untouched
        '{1'b0, 3'd0, 1'b0, 16'h0000, 3'd1, 1'b1, 16'h0000}   // count reg untouched
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; dw_en = 1'b0;
        wr_byte = 1'b0; wr_idx = '0; wr_data = '0;
        dw_lo = '0; dw_hi = '0;
    endtask

    task automatic check_all_zero(input string req);
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            idle_inputs();
            ra_idx = 3'(r); ra_byte = 1'b0;
            rb_idx = 3'(7 - r); rb_byte = 1'b0;
            #4;
            check(req, ra_data, 16'h0000);
            check(req, rb_data, 16'h0000);
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Reset, with a write attempt that must be cleared
        wr_en = 1'b1; wr_idx = 3'd5; wr_data = 16'hDEAD;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle_inputs();
        check_all_zero("R1 reset");

        // Vector table walk: R2 R3 R4 R5 R6 R10
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            wr_en = VEC[v].we; wr_idx = VEC[v].widx;
            wr_byte = VEC[v].wbyte; wr_data = VEC[v].wdata;
            dw_en = 1'b0;
            ra_idx = VEC[v].ridx; ra_byte = VEC[v].rbyte;
            #4;
            check($sformatf("R2/R3/R4/R6 vector %0d", v), ra_data, VEC[v].exp);
        end

        // R7: independent ports, word on A, byte on B
        @(negedge clk);
        idle_inputs();
        ra_idx = 3'd3; ra_byte = 1'b0;
        rb_idx = 3'd6; rb_byte = 1'b1;
        #4;
        check("R7 port A word", ra_data, 16'hBE11);
        check("R7 port B byte", rb_data, 16'h0077);

        // R8: pair load, bypass then stored
        @(negedge clk);
        dw_en = 1'b1; dw_lo = 16'h1111; dw_hi = 16'h2222;
        ra_idx = 3'd0; ra_byte = 1'b0;
        rb_idx = 3'd2; rb_byte = 1'b0;
        #4;
        check("R8 bypass acc", ra_data, 16'h1111);
        check("R8 bypass data reg", rb_data, 16'h2222);
        @(negedge clk);
        idle_inputs();
        ra_idx = 3'd1; rb_idx = 3'd2;
        #4;
        check("R8 count reg unchanged", ra_data, 16'h0000);
        check("R8 data reg stored", rb_data, 16'h2222);

        // R9: pair load against overlapping byte write on acc high
        @(negedge clk);
        dw_en = 1'b1; dw_lo = 16'h3333; dw_hi = 16'h4444;
        wr_en = 1'b1; wr_idx = 3'd4; wr_byte = 1'b1; wr_data = 16'h0099;
        @(negedge clk);
        idle_inputs();
        ra_idx = 3'd0; ra_byte = 1'b0;
        rb_idx = 3'd4; rb_byte = 1'b1;
        #4;
        check("R9 acc takes pair value", ra_data, 16'h3333);
        check("R9 acc high byte", rb_data, 16'h0033);

        // R9: pair load alongside write to base pointer
        @(negedge clk);
        dw_en = 1'b1; dw_lo = 16'h6666; dw_hi = 16'h7777;
        wr_en = 1'b1; wr_idx = 3'd5; wr_byte = 1'b0; wr_data = 16'h5555;
        @(negedge clk);
        idle_inputs();
        ra_idx = 3'd5; ra_byte = 1'b0;
        rb_idx = 3'd2; rb_byte = 1'b0;
        #4;
        check("R9 unrelated write kept", ra_data, 16'h5555);
        check("R9 data reg pair value", rb_data, 16'h7777);

        // R3 R5: both halves of count register on both ports
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd1; wr_byte = 1'b0; wr_data = 16'hA1B2;
        @(negedge clk);
        idle_inputs();
        ra_idx = 3'd5; ra_byte = 1'b1;
        rb_idx = 3'd1; rb_byte = 1'b1;
        #4;
        check("R3 R5 high half zero-extended", ra_data, 16'h00A1);
        check("R3 R5 low half zero-extended", rb_data, 16'h00B2);

        // R1: reset in mid run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all_zero("R1 mid-run reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule